// File: doc/BRIEF.md
# Compare-Match Timer with Sticky Status Flags

This block is a free-running up-counter with two compare channels and three sticky event flags. The counter steps once on every clock cycle where the count-enable tick is high. On that same tick each compare channel checks its register against the counter value. A flag is set when the counter wraps from all ones to zero, or when a channel finds a match. A compare register that holds zero is treated as disarmed and never matches.

The flags sit in a read-only status word. Software clears a flag by writing a one to the matching bit of a separate write-only clear register. A control register enables each flag's interrupt line separately. It also holds a restart option: when that option is set, a match on compare channel 0 makes the counter load zero instead of incrementing. All registers are reached over a plain single-cycle register bus. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `cmt_timer`

## Requirements
- R1: After synchronous reset the counter, both compare registers, the control register and all three flags read 0, and all interrupt outputs are low.
- R2: The counter (read at address 5) increments by one only on clock cycles with `tick` high and holds its value on every other cycle.
- R3: On a tick where the counter holds all ones it wraps to zero and sets the overrun flag, status bit 0 (status is read at address 3).
- R4: On a tick where the counter equals a nonzero compare value, that channel's flag is set in the following cycle. Channel 0 (address 1) sets status bit 1 and channel 1 (address 2) sets status bit 2.
- R5: A compare register holding zero never sets its flag, even when the counter passes through zero.
- R6: With control bit 0 (restart-on-match) set and compare 0 nonzero, a tick on which the counter equals compare 0 loads zero into the counter instead of incrementing it.
- R7: With restart-on-match set and compare 0 at all ones, the restart to zero still sets the overrun flag.
- R8: Writing a one to bit k of the clear register (address 4) clears status bit k. Writing zeros there has no effect, and writes to the status address have no effect.
- R9: When a flag's set condition and its write-one clear occur in the same cycle, the flag ends up set.
- R10: Each interrupt output is high exactly while its flag is set and its enable bit is set. Control bit 1 enables overrun, bit 2 enables compare 0 and bit 3 enables compare 1.
- R11: The control (address 0) and compare registers read back the values written to them, masked to their width, and writing them never changes a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick | input | 1 | Count-enable pulse |
| irq_ovf | output | 1 | Overrun interrupt request |
| irq_cm0 | output | 1 | Compare channel 0 interrupt request |
| irq_cm1 | output | 1 | Compare channel 1 interrupt request |

## Verification
The bench builds the block with an 8-bit counter and a 16-bit data bus. With that setting a full wrap takes only 256 ticks, so the bench can reach the all-ones boundary many times within its run. It covers plain wrap, a zero compare value passing through zero, restart-on-match at a small compare value and at all ones, and a clear that collides with a match. The narrow counter on the wide bus also checks that compare writes are masked and that readback is zero-extended.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_CMP0 = 3'd1,
        ADR_CMP1 = 3'd2,
        ADR_STAT = 3'd3,
        ADR_CLR  = 3'd4,
        ADR_CNT  = 3'd5
    } reg_addr_e;

    localparam int NUM_CMP   = 2;
    localparam int NUM_FLAGS = 3;
    localparam int CTRL_W    = 4;

    // control word: bit0 restart-on-match, bits 3:1 interrupt enables
    typedef struct packed {
        logic en_cm1;
        logic en_cm0;
        logic en_ovf;
        logic restart;
    } ctrl_t;

    // event / flag word: bit0 overrun, bit1 compare 0, bit2 compare 1
    typedef struct packed {
        logic cm1;
        logic cm0;
        logic ovf;
    } evt_t;

    function automatic evt_t flag_next(evt_t cur, evt_t set, evt_t clr);
        return evt_t'((cur & ~clr) | set);
    endfunction

    function automatic evt_t irq_gate(evt_t flags, ctrl_t c);
        evt_t g;
        g.ovf = flags.ovf & c.en_ovf;
        g.cm0 = flags.cm0 & c.en_cm0;
        g.cm1 = flags.cm1 & c.en_cm1;
        return g;
    endfunction

endpackage

// File: rtl/cmt_regfile.sv
module cmt_regfile
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [2:0]                       addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             we,
    output ctrl_t                            ctrl,
    output logic [NUM_CMP-1:0][CNT_W-1:0]    cmp,
    output evt_t                             clr_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && addr == 3'(ADR_CTRL)) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        localparam logic [2:0] SLOT = 3'(ADR_CMP0) + 3'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[k] <= '0;
            end else if (we && addr == SLOT) begin
                cmp[k] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        clr_req = '0;
        if (we && addr == 3'(ADR_CLR)) begin
            clr_req = evt_t'(wdata[NUM_FLAGS-1:0]);
        end
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          restart,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]              cnt,
    output evt_t                          evt
);

    logic [NUM_CMP-1:0] hit;
    logic               at_top;
    logic [CNT_W-1:0]   cnt_d;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_hit
        assign hit[k] = (cmp[k] != '0) && (cnt == cmp[k]);
    end

    assign at_top = &cnt;

    always_comb begin
        evt     = '0;
        evt.ovf = tick & at_top;
        evt.cm0 = tick & hit[0];
        evt.cm1 = tick & hit[1];
    end

    always_comb begin
        cnt_d = cnt;
        if (tick) begin
            if (restart && hit[0]) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/cmt_flags.sv
module cmt_flags
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t set,
    input  evt_t clr,
    output evt_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= flag_next(flags, set, clr);
        end
    end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq_ovf,
    output logic              irq_cm0,
    output logic              irq_cm1
);

    ctrl_t                         ctrl_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
    evt_t                          clr_req;
    evt_t                          evt;
    evt_t                          flags_q;
    evt_t                          irq_v;
    logic [CNT_W-1:0]              cnt_q;

    cmt_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .ctrl    (ctrl_q),
        .cmp     (cmp_q),
        .clr_req (clr_req)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (ctrl_q.restart),
        .cmp     (cmp_q),
        .cnt     (cnt_q),
        .evt     (evt)
    );

    cmt_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (evt),
        .clr   (clr_req),
        .flags (flags_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            3'(ADR_CTRL): bus_rdata = DATA_W'(ctrl_q);
            3'(ADR_CMP0): bus_rdata = DATA_W'(cmp_q[0]);
            3'(ADR_CMP1): bus_rdata = DATA_W'(cmp_q[1]);
            3'(ADR_STAT): bus_rdata = DATA_W'(flags_q);
            3'(ADR_CNT):  bus_rdata = DATA_W'(cnt_q);
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_v   = irq_gate(flags_q, ctrl_q);
    assign irq_ovf = irq_v.ovf;
    assign irq_cm0 = irq_v.cm0;
    assign irq_cm1 = irq_v.cm1;

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp0,
    input logic [CNT_W-1:0]  cmp1,
    input logic              restart,
    input logic [2:0]        flags
);

    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == 3'(ADR_CLR));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt)) |=> flags[0]);

    // also covers R9: a match wins over a same-cycle clear
    p_cm1_set_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp1 != '0 && cnt == cmp1) |=> flags[2]);

    p_zero_cmp_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp0 == '0 && !flags[1]) |=> !flags[1]);

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && restart && cmp0 != '0 && cnt == cmp0) |=> (cnt == '0));

    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && bus_wdata[0] && !(tick && (&cnt))) |=> !flags[0]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && flags[0]) |=> flags[0]);

endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .cmp0      (cmp_q[0]),
    .cmp1      (cmp_q[1]),
    .restart   (ctrl_q.restart),
    .flags     (flags_q)
);

// File: tb/cmt_timer_tb_top.sv
module cmt_timer_tb_top;

    localparam int BW   = 8;
    localparam int DW   = 16;
    localparam int MAXV = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          tick = 1'b0;
    logic          irq_ovf, irq_cm0, irq_cm1;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    int m_cnt, m_cmp0, m_cmp1, m_ctrl, m_flags;

    // 4 time units per period: 250 MHz
    always #2 clk = ~clk;

    cmt_timer #(.CNT_W(BW), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .irq_ovf   (irq_ovf),
        .irq_cm0   (irq_cm0),
        .irq_cm1   (irq_cm1)
    );

    function automatic void model_step(int a, int wd, bit we, bit tk);
        int set_m, clr_m, nxt;
        if (rst) begin
            m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0; m_ctrl = 0; m_flags = 0;
            return;
        end
        set_m = 0;
        nxt   = m_cnt;
        if (tk) begin
            if (m_cnt == MAXV) set_m |= 1;
            if (m_cmp0 != 0 && m_cnt == m_cmp0) set_m |= 2;
            if (m_cmp1 != 0 && m_cnt == m_cmp1) set_m |= 4;
            if ((m_ctrl & 1) != 0 && m_cmp0 != 0 && m_cnt == m_cmp0) nxt = 0;
            else nxt = (m_cnt + 1) % (MAXV + 1);
        end
        clr_m = (we && a == 4) ? (wd & 7) : 0;
        m_flags = (m_flags & ~clr_m & 7) | set_m;
        if (we && a == 0) m_ctrl = wd & 15;
        if (we && a == 1) m_cmp0 = wd & MAXV;
        if (we && a == 2) m_cmp1 = wd & MAXV;
        m_cnt = nxt;
    endfunction

    function automatic int model_rd(int a);
        case (a)
            0: return m_ctrl;
            1: return m_cmp0;
            2: return m_cmp1;
            3: return m_flags;
            5: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int a, int wd, bit we, bit tk, string req);
        int exp_irq;
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = DW'(wd);
        bus_we    = we;
        tick      = tk;
        @(posedge clk);
        model_step(a, wd, we, tk);
        #1;
        exp_irq = m_flags & (m_ctrl >> 1);
        check(req, "rdata", int'(bus_rdata), model_rd(a));
        check(req, "irq", int'({irq_cm1, irq_cm0, irq_ovf}), exp_irq);
    endtask

    task automatic run_until(int target, int a, string req);
        for (int g = 0; g < 1000 && m_cnt != target; g++) cyc(a, 0, 0, 1, req);
    endtask

    initial begin
        // R1: reset state on every readable address
        for (int a = 0; a < 6; a++) cyc(a, 0, 0, 0, "R1");
        rst = 1'b0;
        for (int a = 0; a < 6; a++) cyc(a, 0, 0, 0, "R1");

        // R11: register readback, masking of the compare width
        cyc(0, 'h1E, 1, 0, "R11");
        cyc(1, 'h310, 1, 0, "R11");
        cyc(1, 10, 1, 0, "R11");
        cyc(2, 20, 1, 0, "R11");
        cyc(1, 0, 0, 0, "R11");

        // R2: irregular tick pattern on the counter
        for (int i = 0; i < 30; i++) cyc(5, 0, 0, (i % 3) != 0, "R2");
        // R4: both channels match
        for (int i = 0; i < 15; i++) cyc(3, 0, 0, 1, "R4");

        // R8: zero clear and status write ignored, then one clear
        cyc(4, 0, 1, 0, "R8");
        cyc(3, 7, 1, 0, "R8");
        cyc(4, 2, 1, 0, "R8");
        cyc(3, 0, 0, 0, "R8");

        // R3: plain wrap
        run_until(MAXV, 5, "R3");
        cyc(3, 0, 0, 1, "R3");
        cyc(5, 0, 0, 0, "R3");

        // R5: zero compare passes through zero
        cyc(4, 7, 1, 0, "R5");
        cyc(1, 0, 1, 0, "R5");
        for (int i = 0; i < 300; i++) cyc(3, 0, 0, 1, "R5");

        // R11: compare write with flags set
        cyc(2, 33, 1, 0, "R11");
        cyc(3, 0, 0, 0, "R11");

        // R9: clear of compare 1 on its matching tick
        cyc(4, 7, 1, 0, "R9");
        run_until(33, 3, "R9");
        cyc(4, 4, 1, 1, "R9");
        cyc(3, 0, 0, 0, "R9");
        cyc(4, 3, 1, 0, "R9");
        cyc(3, 0, 0, 0, "R9");

        // R10: interrupt gating
        run_until(MAXV, 3, "R10");
        cyc(3, 0, 0, 1, "R10");
        cyc(0, 0, 1, 0, "R10");
        cyc(0, 'h4, 1, 0, "R10");
        cyc(0, 'h2, 1, 0, "R10");
        cyc(0, 'h8, 1, 0, "R10");
        cyc(0, 'hE, 1, 0, "R10");

        // R6: restart on match at a small value
        cyc(4, 7, 1, 0, "R6");
        cyc(1, 5, 1, 0, "R6");
        cyc(0, 'hF, 1, 0, "R6");
        for (int i = 0; i < 300; i++) cyc((i % 2) ? 3 : 5, 0, 0, 1, "R6");

        // R7: restart at all ones still flags overrun
        cyc(4, 7, 1, 0, "R7");
        cyc(1, MAXV, 1, 0, "R7");
        for (int i = 0; i < 600; i++) cyc((i % 2) ? 3 : 5, 0, 0, 1, "R7");
        cyc(4, 1, 1, 0, "R7");
        for (int i = 0; i < 300; i++) cyc((i % 2) ? 3 : 5, 0, 0, (i % 4) != 3, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule